// File: doc/BRIEF.md
# Scanline Sync Sequencer

This block produces the timing for one progressive-style monochrome composite video frame, one line at a time. A clock divider turns the system clock into sample periods. A sample counter walks across each line, and a line counter walks down the frame. At every line boundary a small mode machine decides what the next line carries: picture lines with a horizontal sync pulse, blank lines with a horizontal sync pulse, or vertical-sync lines. Vertical-sync lines carry narrow pulses at twice the line rate.

Each sample is a 2-bit level code that feeds an external resistor DAC. Picture dots come from a 1-bit `pixel_i` input, which an outside pixel memory supplies. The block tells that memory which bank and which bit lane the current line uses. Dots can be enabled on every picture line, or on one chosen line only.

At two points in each frame, entering the bottom blank region and entering the top blank region, the block raises a strobe of programmable length. Other logic uses this strobe as a window in which shared memory is free of video fetches.

Top module: `scan_line_seq`

## Requirements
- R1: Every output sample lasts SAMPLE_CLKS clocks. `level_o` changes only on the clock edge that starts a sample. It is 0 (sync) during reset, and after reset it shows sample 0 of line 0 from the first clock edge onward.
- R2: `line_o` advances by one only on the edge that ends the last sample of a line. It counts 0 to TOTAL_LINES-1 and wraps to 0. TOTAL_LINES is the sum of the picture, bottom blank, vertical-sync and top blank line counts.
- R3: The level codes are 0 for sync, 1 for blank and 3 for a white dot; code 2 never appears. On any line that is not a vertical-sync line, samples 0 to HSYNC_LEN-1 are sync. The remaining samples are blank, except for dots inside the picture window.
- R4: Vertical-sync lines are the lines ACTIVE_LINES+BOTTOM_LINES up to ACTIVE_LINES+BOTTOM_LINES+VSYNC_LINES-1. On these lines the level is sync for HSYNC_LEN/2 samples starting at sample 0, and again starting at sample LINE_SAMPLES/2. It is blank elsewhere.
- R5: In all-lines mode, on picture lines 0 to ACTIVE_LINES-1, samples HSYNC_LEN+BPORCH_LEN up to LINE_SAMPLES-FPORCH_LEN-1 are white when `pixel_i` is high at the start of the sample, and blank otherwise.
- R6: When the last top blank line ends, `sel_line_i` is captured. A nonzero value selects single-line mode for the next frame; zero selects all-lines mode. In single-line mode, dots appear only on the picture line whose number equals the captured value.
- R7: The first frame after reset runs in all-lines mode whatever `sel_line_i` holds.
- R8: Bottom blank, vertical-sync and top blank lines never carry a white level.
- R9: The task window opens on two end-of-line edges: the one that leaves the last picture line, and the one that leaves the last vertical-sync line. `task_o` is then high for `task_len_i` clocks, starting with that edge. A length of 0 gives no pulse.
- R10: For line count n, `bank_o` equals bit 2 of n+1 and `lane_o` equals 3 minus the low two bits of n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_line_i | input | LINE_W | Selected picture line; 0 picks all-lines mode |
| task_len_i | input | TASK_W | Task window length in clocks |
| pixel_i | input | 1 | Dot value for the sample being started |
| level_o | output | 2 | Level code: 0 sync, 1 blank, 3 white |
| line_o | output | LINE_W | Current line count |
| bank_o | output | 1 | Pixel memory bank for the current line |
| lane_o | output | 2 | Bit lane within the bank for the current line |
| task_o | output | 1 | Shared-memory task window |

## Verification
A divider phase that slips moves every level edge by whole clocks. The very next line then shows its sync pulse shifted against the arithmetic schedule. A line counter or mode state that is wrong shows up within one line period, in one of three ways: white dots on a blank line, a missing double-rate pulse in the vertical interval, or a bank and lane that disagree with `line_o`. A mode choice that is latched incorrectly shows up only in the second frame after reset. For that reason every configuration runs three full frames at a reduced line length, and each clock is compared.

// File: rtl/scan_seq_pkg.sv
`timescale 1ns/1ps
package scan_seq_pkg;
  typedef enum logic [2:0] {
    M_ALL    = 3'd0,
    M_SINGLE = 3'd1,
    M_BOTTOM = 3'd2,
    M_VSYNC  = 3'd3,
    M_TOP    = 3'd4
  } line_mode_e;

  typedef enum logic [1:0] {
    LV_SYNC  = 2'd0,
    LV_BLANK = 2'd1,
    LV_WHITE = 2'd3
  } level_e;
endpackage

// File: rtl/scan_seq_timing.sv
`timescale 1ns/1ps
module scan_seq_timing #(
  parameter int SAMPLE_CLKS  = 6,
  parameter int LINE_SAMPLES = 635,
  parameter int TOTAL_LINES  = 262,
  parameter int SAMP_W       = $clog2(LINE_SAMPLES),
  parameter int LINE_W       = $clog2(TOTAL_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              ld_o,
  output logic              eol_o,
  output logic [SAMP_W-1:0] samp_o,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [SAMP_W-1:0] LAST_SAMP = SAMP_W'(LINE_SAMPLES - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

  logic tick;

  if (SAMPLE_CLKS > 1) begin : g_div
    localparam int PH_W = $clog2(SAMPLE_CLKS);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(SAMPLE_CLKS - 1);
    logic [PH_W-1:0] ph_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              ph_q <= '0;
      else if (ph_q == LAST_PH) ph_q <= '0;
      else                      ph_q <= ph_q + 1'b1;
    end
    assign ld_o = (ph_q == '0);
    assign tick = (ph_q == LAST_PH);
  end else begin : g_nodiv
    assign ld_o = 1'b1;
    assign tick = 1'b1;
  end

  logic [SAMP_W-1:0] samp_q;
  logic [LINE_W-1:0] line_q;

  assign eol_o = tick && (samp_q == LAST_SAMP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
    end else if (tick) begin
      samp_q <= (samp_q == LAST_SAMP) ? '0 : samp_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
    end else if (eol_o) begin
      line_q <= (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    end
  end

  assign samp_o = samp_q;
  assign line_o = line_q;
endmodule

// File: rtl/scan_seq_mode.sv
`timescale 1ns/1ps
module scan_seq_mode
  import scan_seq_pkg::*;
#(
  parameter int ACTIVE_LINES = 243,
  parameter int BOTTOM_LINES = 4,
  parameter int VSYNC_LINES  = 3,
  parameter int TOP_LINES    = 12,
  parameter int LINE_W       = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              eol_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] sel_i,
  output line_mode_e        mode_o,
  output logic [LINE_W-1:0] sel_q_o,
  output logic              task_start_o
);
  localparam logic [LINE_W-1:0] ACT_END = LINE_W'(ACTIVE_LINES - 1);
  localparam logic [LINE_W-1:0] BOT_END = LINE_W'(ACTIVE_LINES + BOTTOM_LINES - 1);
  localparam logic [LINE_W-1:0] VS_END  = LINE_W'(ACTIVE_LINES + BOTTOM_LINES + VSYNC_LINES - 1);
  localparam logic [LINE_W-1:0] TOP_END =
    LINE_W'(ACTIVE_LINES + BOTTOM_LINES + VSYNC_LINES + TOP_LINES - 1);

  line_mode_e        mode_q, mode_d;
  logic [LINE_W-1:0] sel_q, sel_d;

  always_comb begin
    mode_d = mode_q;
    sel_d  = sel_q;
    if (eol_i) begin
      case (mode_q)
        M_ALL, M_SINGLE: if (line_i == ACT_END) mode_d = M_BOTTOM;
        M_BOTTOM:        if (line_i == BOT_END) mode_d = M_VSYNC;
        M_VSYNC:         if (line_i == VS_END)  mode_d = M_TOP;
        M_TOP: begin
          if (line_i == TOP_END) begin
            sel_d  = sel_i;
            mode_d = (sel_i != '0) ? M_SINGLE : M_ALL;
          end
        end
        default:         mode_d = M_ALL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_ALL;
      sel_q  <= '0;
    end else begin
      mode_q <= mode_d;
      sel_q  <= sel_d;
    end
  end

  // Window opens when leaving picture lines and when leaving vertical sync
  assign task_start_o = eol_i &&
    (((mode_q == M_ALL || mode_q == M_SINGLE) && line_i == ACT_END) ||
     (mode_q == M_VSYNC && line_i == VS_END));

  assign mode_o  = mode_q;
  assign sel_q_o = sel_q;
endmodule

// File: rtl/scan_seq_level.sv
`timescale 1ns/1ps
module scan_seq_level
  import scan_seq_pkg::*;
#(
  parameter int LINE_SAMPLES = 635,
  parameter int HSYNC_LEN    = 47,
  parameter int BPORCH_LEN   = 57,
  parameter int FPORCH_LEN   = 15,
  parameter int SAMP_W       = 10,
  parameter int LINE_W       = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  line_mode_e        mode_i,
  input  logic [SAMP_W-1:0] samp_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] sel_i,
  input  logic              pixel_i,
  output logic [1:0]        level_o
);
  localparam int HALF   = LINE_SAMPLES / 2;
  localparam int EQ_LEN = (HSYNC_LEN / 2 > 0) ? HSYNC_LEN / 2 : 1;
  localparam logic [SAMP_W-1:0] HS_END  = SAMP_W'(HSYNC_LEN);
  localparam logic [SAMP_W-1:0] EQ_END  = SAMP_W'(EQ_LEN);
  localparam logic [SAMP_W-1:0] EQ2_LO  = SAMP_W'(HALF);
  localparam logic [SAMP_W-1:0] EQ2_HI  = SAMP_W'(HALF + EQ_LEN);
  localparam logic [SAMP_W-1:0] ACT_LO  = SAMP_W'(HSYNC_LEN + BPORCH_LEN);
  localparam logic [SAMP_W-1:0] ACT_HI  = SAMP_W'(LINE_SAMPLES - FPORCH_LEN);

  logic   in_eq, in_win, dots_on;
  level_e lvl_d;
  logic [1:0] level_q;

  assign in_eq   = (samp_i < EQ_END) || (samp_i >= EQ2_LO && samp_i < EQ2_HI);
  assign in_win  = (samp_i >= ACT_LO) && (samp_i < ACT_HI);
  assign dots_on = (mode_i == M_ALL) || (mode_i == M_SINGLE && line_i == sel_i);

  always_comb begin
    if (mode_i == M_VSYNC)             lvl_d = in_eq ? LV_SYNC : LV_BLANK;
    else if (samp_i < HS_END)          lvl_d = LV_SYNC;
    else if (in_win && dots_on && pixel_i) lvl_d = LV_WHITE;
    else                               lvl_d = LV_BLANK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   level_q <= LV_SYNC;
    else if (ld_i) level_q <= lvl_d;
  end

  assign level_o = level_q;
endmodule

// File: rtl/scan_seq_task.sv
`timescale 1ns/1ps
module scan_seq_task #(
  parameter int TASK_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TASK_W-1:0] len_i,
  output logic              task_o
);
  logic [TASK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign task_o = (cnt_q != '0);
endmodule

// File: rtl/scan_line_seq.sv
`timescale 1ns/1ps
module scan_line_seq
  import scan_seq_pkg::*;
#(
  parameter int SAMPLE_CLKS  = 6,
  parameter int LINE_SAMPLES = 635,
  parameter int HSYNC_LEN    = 47,
  parameter int BPORCH_LEN   = 57,
  parameter int FPORCH_LEN   = 15,
  parameter int ACTIVE_LINES = 243,
  parameter int BOTTOM_LINES = 4,
  parameter int VSYNC_LINES  = 3,
  parameter int TOP_LINES    = 12,
  parameter int TASK_W       = 8,
  localparam int TOTAL_LINES = ACTIVE_LINES + BOTTOM_LINES + VSYNC_LINES + TOP_LINES,
  localparam int LINE_W      = $clog2(TOTAL_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LINE_W-1:0] sel_line_i,
  input  logic [TASK_W-1:0] task_len_i,
  input  logic              pixel_i,
  output logic [1:0]        level_o,
  output logic [LINE_W-1:0] line_o,
  output logic              bank_o,
  output logic [1:0]        lane_o,
  output logic              task_o
);
  localparam int SAMP_W = $clog2(LINE_SAMPLES);

  logic              ld, eol, task_start;
  logic [SAMP_W-1:0] samp;
  logic [LINE_W-1:0] line, sel_q, line_nx;
  line_mode_e        mode_q;

  scan_seq_timing #(
    .SAMPLE_CLKS (SAMPLE_CLKS),
    .LINE_SAMPLES(LINE_SAMPLES),
    .TOTAL_LINES (TOTAL_LINES),
    .SAMP_W      (SAMP_W),
    .LINE_W      (LINE_W)
  ) u_tim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_o  (ld),
    .eol_o (eol),
    .samp_o(samp),
    .line_o(line)
  );

  scan_seq_mode #(
    .ACTIVE_LINES(ACTIVE_LINES),
    .BOTTOM_LINES(BOTTOM_LINES),
    .VSYNC_LINES (VSYNC_LINES),
    .TOP_LINES   (TOP_LINES),
    .LINE_W      (LINE_W)
  ) u_mode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eol_i       (eol),
    .line_i      (line),
    .sel_i       (sel_line_i),
    .mode_o      (mode_q),
    .sel_q_o     (sel_q),
    .task_start_o(task_start)
  );

  scan_seq_level #(
    .LINE_SAMPLES(LINE_SAMPLES),
    .HSYNC_LEN   (HSYNC_LEN),
    .BPORCH_LEN  (BPORCH_LEN),
    .FPORCH_LEN  (FPORCH_LEN),
    .SAMP_W      (SAMP_W),
    .LINE_W      (LINE_W)
  ) u_lvl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .mode_i (mode_q),
    .samp_i (samp),
    .line_i (line),
    .sel_i  (sel_q),
    .pixel_i(pixel_i),
    .level_o(level_o)
  );

  scan_seq_task #(
    .TASK_W(TASK_W)
  ) u_task (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(task_start),
    .len_i  (task_len_i),
    .task_o (task_o)
  );

  // Bank and lane rotate with the low three line bits
  assign line_nx = line + 1'b1;
  assign bank_o  = line_nx[2];
  assign lane_o  = 2'd3 - line[1:0];
  assign line_o  = line;
endmodule

// File: rtl/scan_line_seq_chk.sv
`timescale 1ns/1ps
module scan_line_seq_chk
  import scan_seq_pkg::*;
#(
  parameter int TOTAL_LINES = 262,
  parameter int LINE_W      = 9,
  parameter int TASK_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_i,
  input logic              eol_i,
  input line_mode_e        mode_i,
  input logic [1:0]        level_i,
  input logic [LINE_W-1:0] line_i,
  input logic              task_i,
  input logic [TASK_W-1:0] task_len_i
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES - 1);

  AST_LEVEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(level_i)); // R1

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eol_i |=> $stable(line_i)); // R2

  AST_LINE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eol_i && line_i == LAST_LINE) |=> (line_i == '0)); // R2

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_i <= LAST_LINE); // R2

  AST_NO_CODE2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i != 2'd2); // R3

  AST_BLANK_DARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && (mode_i == M_BOTTOM || mode_i == M_VSYNC || mode_i == M_TOP))
      |=> (level_i != LV_WHITE)); // R8

  AST_TASK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (task_len_i == '0 && !task_i) |=> !task_i); // R9
endmodule

bind scan_line_seq scan_line_seq_chk #(
  .TOTAL_LINES(TOTAL_LINES),
  .LINE_W     (LINE_W),
  .TASK_W     (TASK_W)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld_i      (ld),
  .eol_i     (eol),
  .mode_i    (mode_q),
  .level_i   (level_o),
  .line_i    (line_o),
  .task_i    (task_o),
  .task_len_i(task_len_i)
);

// File: tb/scan_line_seq_tb_top.sv
`timescale 1ns/1ps
module scan_line_seq_tb_top;
  localparam int SC  = 2;
  localparam int LS  = 16;
  localparam int HS  = 2;
  localparam int BP  = 2;
  localparam int FP  = 2;
  localparam int NA  = 10;
  localparam int NB  = 2;
  localparam int NV  = 2;
  localparam int NT  = 3;
  localparam int TOT = NA + NB + NV + NT;
  localparam int LW  = $clog2(TOT);
  localparam int TW  = 4;
  localparam int LINE_CLK = SC * LS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [LW-1:0] sel = '0;
  logic [TW-1:0] len = '0;
  logic          pix = 1'b0;
  logic [1:0]    level;
  logic [LW-1:0] line;
  logic          bank;
  logic [1:0]    lane;
  logic          tsk;

  int nvec = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  scan_line_seq #(
    .SAMPLE_CLKS (SC),
    .LINE_SAMPLES(LS),
    .HSYNC_LEN   (HS),
    .BPORCH_LEN  (BP),
    .FPORCH_LEN  (FP),
    .ACTIVE_LINES(NA),
    .BOTTOM_LINES(NB),
    .VSYNC_LINES (NV),
    .TOP_LINES   (NT),
    .TASK_W      (TW)
  ) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sel_line_i(sel),
    .task_len_i(len),
    .pixel_i   (pix),
    .level_o   (level),
    .line_o    (line),
    .bank_o    (bank),
    .lane_o    (lane),
    .task_o    (tsk)
  );

  function automatic logic pix_at(input int c);
    return (((c / 3) + (c / 7)) % 2) == 1;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected level after edge c (c >= 1)
  task automatic exp_level(input int c, input int s_sel, output int lv, output string tag);
    int g, s, ln, fr;
    logic dots;
    g  = (c - 1) / SC;
    s  = g % LS;
    ln = (g / LS) % TOT;
    fr = g / (LS * TOT);
    if (ln >= NA + NB && ln < NA + NB + NV) begin
      tag = "R4";
      lv  = ((s < HS / 2) || (s >= LS / 2 && s < LS / 2 + HS / 2)) ? 0 : 1;
    end else if (s < HS) begin
      tag = "R3";
      lv  = 0;
    end else if (ln >= NA) begin
      tag = "R8";
      lv  = 1;
    end else if (s >= HS + BP && s < LS - FP) begin
      if (fr == 0) begin
        tag = "R7"; dots = 1'b1;
      end else if (s_sel != 0) begin
        tag = "R6"; dots = (ln == s_sel);
      end else begin
        tag = "R5"; dots = 1'b1;
      end
      lv = (dots && pix_at(SC * g + 1)) ? 3 : 1;
    end else begin
      tag = "R3";
      lv  = 1;
    end
  endtask

  task automatic run(input int s_sel, input int l_len);
    int    el, m, ml, elv, etk;
    string tag;
    rst_n = 1'b0;
    sel   = LW'(s_sel);
    len   = TW'(l_len);
    pix   = pix_at(1);
    repeat (3) @(negedge clk);
    chk("R1", "reset level", int'(level), 0);
    chk("R2", "reset line", int'(line), 0);
    chk("R9", "reset task", int'(tsk), 0);
    rst_n = 1'b1;
    for (int c = 1; c <= 3 * TOT * LINE_CLK; c++) begin
      @(posedge clk);
      @(negedge clk);
      exp_level(c, s_sel, elv, tag);
      chk(tag, "level", int'(level), elv);
      el = (c / LINE_CLK) % TOT;
      chk("R2", "line", int'(line), el);
      chk("R10", "bank", int'(bank), ((el + 1) >> 2) & 1);
      chk("R10", "lane", int'(lane), 3 - (el & 3));
      m   = c / LINE_CLK;
      ml  = m % TOT;
      etk = ((ml == NA || ml == NA + NB + NV) && (c - m * LINE_CLK) < l_len) ? 1 : 0;
      chk("R9", "task", int'(tsk), etk);
      pix = pix_at(c + 1);
    end
  endtask

  initial begin
    run(0, 3);
    run(5, 1);
    run(9, 0);
    run(15, 7);
    run(1, 15);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(5 * 150000);
    nerr++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule